// File: doc/BRIEF.md
# Paged Graphic LCD Host Port

This block is the processor-facing front end of a 64-line by 128-column monochrome graphic display controller. The columns are split into two halves of 64. Each half has its own active-low select line, its own byte-wide display memory organised as 8 pages of 8 lines, and its own page, column and start-line registers. A host drives a byte bus, a register-select line, a read/write line and an enable strobe. The block turns these into data reads, data writes, status reads and instruction writes against one half or, for writes, both halves at once.

All host inputs are sampled on the system clock, and a falling edge of the enable strobe is detected one clock edge after it occurs. Writes and instructions act at that detected edge. Display reads go through a one-byte bus buffer. While the strobe is high the bus shows the byte the buffer already holds. At the falling edge the buffer is refilled from the current page and column, and the column steps on. After an address change, the first read therefore yields stale data. Each accepted access starts a short busy window, and the block drops any non-status cycle that arrives inside it. The display on/off state and the start line of each half are brought out as ports for the scan logic.

Top module: `lcd_host_if`

## Requirements
- R1: The pair {rs, rw} selects the cycle type: 11 is a data read, 10 a data write, 01 a status read and 00 an instruction write. Writes and instructions take effect at the first rising clock edge at which `en` is sampled low after having been high.
- R2: Instruction codes are 0011111D for display on/off (D=1 turns the display on), 01CCCCCC for loading the column, 10111PPP for loading the page and 11SSSSSS for loading the start line. Any other byte changes nothing. The display state of half h is `disp_on[h]`, and its start line is `start_line[6h+5:6h]`.
- R3: A status read returns bit 7 = busy (set during reset as well), bit 5 = display off (1 when the display is off), bit 4 = reset in progress, and 0 in every other bit.
- R4: Every accepted data read or write increments the 6-bit column by one, with 63 wrapping to 0. Data accesses leave the page and the start line unchanged.
- R5: A data read drives the bus-buffer byte, which is 0x00 after reset. At the strobe's falling edge the buffer loads the byte at the current page and column. The first read after an address change therefore returns the previous buffer contents.
- R6: `cs_n[0]` low selects half 0 and `cs_n[1]` low selects half 1. With both high, the bus is not driven and nothing changes. A write or instruction with both low goes to both halves. A read with both low drives nothing.
- R7: `db_oe` is high only while `en` is high, `rw` is high and exactly one select is low.
- R8: While `rst_n` is low, every half has start line 0 and display off. Status reads are still answered (0xB0), and every other cycle is ignored.
- R9: An accepted non-status cycle makes its half busy for BUSY_CYCLES clocks. A strobe fall detected 1 to BUSY_CYCLES clocks after the accepted one is ignored, and one detected at BUSY_CYCLES+1 clocks is accepted. Status reads never set busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 2 | Active-low half selects, bit h for half h |
| rs | input | 1 | Register select: 1 data, 0 control |
| rw | input | 1 | 1 read, 0 write |
| en | input | 1 | Enable strobe |
| db_i | input | 8 | Host-to-block data |
| db_o | output | 8 | Block-to-host data |
| db_oe | output | 1 | Output enable for the data bus |
| disp_on | output | 2 | Display-on state per half |
| start_line | output | 12 | Start line per half, 6 bits each |

## Verification
Two things can fall on the same clock edge. The first is a fresh strobe fall landing on the edge at which the busy window of the previous access runs out. The bench places instruction strobes exactly BUSY_CYCLES and BUSY_CYCLES+1 clocks after an accepted one, then reads the start-line port to see which strobe took effect. The second is a write with both selects low, which updates both halves at the same edge. The bench performs such a write and reads the byte back from each half in turn, after a dummy read, to confirm that both halves stored it.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;

   // Field widths fixed by the instruction encoding
   localparam int BYTE_W    = 8;
   localparam int ARG_W     = 6;
   localparam int MAX_COL_W = 6;
   localparam int MAX_PG_W  = 3;
   localparam int MAX_LN_W  = 6;

   // Cycle kind, encoded as {rs, rw}
   typedef enum logic [1:0] {
      CYC_INSTR  = 2'b00,
      CYC_STATUS = 2'b01,
      CYC_DWRITE = 2'b10,
      CYC_DREAD  = 2'b11
   } cyc_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_DISP,
      OP_COL,
      OP_PAGE,
      OP_START
   } op_e;

   typedef struct packed {
      op_e              op;
      logic [ARG_W-1:0] arg;
   } cmd_t;

   function automatic logic [BYTE_W-1:0] status_byte(input logic busy,
                                                     input logic on,
                                                     input logic in_rst);
      return {busy | in_rst, 1'b0, ~on, in_rst, 4'b0000};
   endfunction

endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
   import lcd_host_pkg::*;
(
   input  logic [BYTE_W-1:0] code,
   output cmd_t              cmd
);

   always_comb begin
      cmd.op  = OP_NONE;
      cmd.arg = code[ARG_W-1:0];
      if (code[7:6] == 2'b11) begin
         cmd.op = OP_START;
      end else if (code[7:6] == 2'b01) begin
         cmd.op = OP_COL;
      end else if (code[7:3] == 5'b10111) begin
         cmd.op  = OP_PAGE;
         cmd.arg = {3'b000, code[2:0]};
      end else if (code[7:1] == 7'b0011111) begin
         cmd.op  = OP_DISP;
         cmd.arg = {5'b00000, code[0]};
      end
   end

endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);

   localparam int CNT_W = $clog2(CYCLES + 1);

   generate
      if (CYCLES == 1) begin : g_single
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= load;
         end
         assign busy = busy_q;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          cnt <= '0;
            else if (load)       cnt <= CNT_W'(CYCLES);
            else if (cnt != '0)  cnt <= cnt - 1'b1;
         end
         assign busy = (cnt != '0);

         AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1)); // R9
      end
   endgenerate

endmodule

// File: rtl/lcd_half_ctrl.sv
module lcd_half_ctrl
   import lcd_host_pkg::*;
#(
   parameter int PAGES       = 8,
   parameter int COLS        = 64,
   parameter int LINES       = 64,
   parameter int BUSY_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic              sel,
   input  cyc_e              cyc,
   input  logic [BYTE_W-1:0] din,
   input  cmd_t              cmd,
   output logic [BYTE_W-1:0] rd_buf,
   output logic              busy,
   output logic              disp_on,
   output logic [$clog2(LINES)-1:0] start_line
);

   localparam int PAGE_W = $clog2(PAGES);
   localparam int COL_W  = $clog2(COLS);
   localparam int LINE_W = $clog2(LINES);
   localparam int ADDR_W = PAGE_W + COL_W;
   localparam int DEPTH  = PAGES * COLS;

   logic [PAGE_W-1:0] page;
   logic [COL_W-1:0]  col;
   logic [BYTE_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] addr;

   logic accept, do_read, do_write, do_instr;

   assign accept   = strobe & sel & ~busy;
   assign do_read  = accept & (cyc == CYC_DREAD);
   assign do_write = accept & (cyc == CYC_DWRITE);
   assign do_instr = accept & (cyc == CYC_INSTR);
   assign addr     = {page, col};

   lcd_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (do_read | do_write | do_instr),
      .busy  (busy)
   );

   // Address and control registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page       <= '0;
         col        <= '0;
         start_line <= '0;
         disp_on    <= 1'b0;
      end else if (do_read || do_write) begin
         col <= col + 1'b1;
      end else if (do_instr) begin
         case (cmd.op)
            OP_DISP:  disp_on    <= cmd.arg[0];
            OP_COL:   col        <= cmd.arg[COL_W-1:0];
            OP_PAGE:  page       <= cmd.arg[PAGE_W-1:0];
            OP_START: start_line <= cmd.arg[LINE_W-1:0];
            default:  ;
         endcase
      end
   end

   // Display memory, no reset
   always_ff @(posedge clk) begin
      if (do_write) mem[addr] <= din;
   end

   // One-deep read buffer: prefetch on each accepted read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_buf <= '0;
      else if (do_read) rd_buf <= mem[addr];
   end

   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (do_read || do_write) |=> (col == $past(col) + 1'b1)); // R4
   AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (do_read || do_write) |=> ($stable(page) && $stable(start_line))); // R4
   AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !do_read |=> $stable(rd_buf)); // R5
   AST_BUSY_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
      (do_read || do_write || do_instr) |=> busy); // R9

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_STATE: assert (start_line == '0 && !disp_on); // R8
      end
   end

endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
   import lcd_host_pkg::*;
#(
   parameter int N_HALF      = 2,
   parameter int PAGES       = 8,
   parameter int COLS        = 64,
   parameter int LINES       = 64,
   parameter int BUSY_CYCLES = 4,
   localparam int LINE_W     = $clog2(LINES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_HALF-1:0]        cs_n,
   input  logic                     rs,
   input  logic                     rw,
   input  logic                     en,
   input  logic [7:0]               db_i,
   output logic [7:0]               db_o,
   output logic                     db_oe,
   output logic [N_HALF-1:0]        disp_on,
   output logic [N_HALF*LINE_W-1:0] start_line
);

   initial begin
      assert (N_HALF >= 1) else $error("N_HALF must be at least 1");
      assert (PAGES >= 2 && PAGES <= (1 << MAX_PG_W) && (PAGES & (PAGES - 1)) == 0)
         else $error("PAGES must be a power of two from 2 to 8");
      assert (COLS >= 2 && COLS <= (1 << MAX_COL_W) && (COLS & (COLS - 1)) == 0)
         else $error("COLS must be a power of two from 2 to 64");
      assert (LINES >= 2 && LINES <= (1 << MAX_LN_W) && (LINES & (LINES - 1)) == 0)
         else $error("LINES must be a power of two from 2 to 64");
      assert (BUSY_CYCLES >= 1) else $error("BUSY_CYCLES must be at least 1");
   end

   logic        en_q;
   logic        strobe;
   logic        one_sel;
   cyc_e        cyc;
   cmd_t        cmd;
   logic [N_HALF-1:0] sel;
   logic [N_HALF-1:0] busy_h;
   logic [7:0]  buf_h [N_HALF];
   logic [7:0]  pick_buf;
   logic        pick_busy, pick_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en;
   end

   assign strobe  = en_q & ~en;
   assign one_sel = $onehot(~cs_n);
   assign cyc     = cyc_e'({rs, rw});

   lcd_cmd_decode u_dec (
      .code (db_i),
      .cmd  (cmd)
   );

   generate
      for (genvar h = 0; h < N_HALF; h++) begin : g_half
         // reads need exactly one select; writes reach every selected half
         assign sel[h] = ~cs_n[h] & (~rw | one_sel);

         lcd_half_ctrl #(
            .PAGES       (PAGES),
            .COLS        (COLS),
            .LINES       (LINES),
            .BUSY_CYCLES (BUSY_CYCLES)
         ) u_half (
            .clk        (clk),
            .rst_n      (rst_n),
            .strobe     (strobe),
            .sel        (sel[h]),
            .cyc        (cyc),
            .din        (db_i),
            .cmd        (cmd),
            .rd_buf     (buf_h[h]),
            .busy       (busy_h[h]),
            .disp_on    (disp_on[h]),
            .start_line (start_line[h*LINE_W +: LINE_W])
         );
      end
   endgenerate

   // Return path from the single selected half
   always_comb begin
      pick_buf  = '0;
      pick_busy = 1'b0;
      pick_on   = 1'b0;
      for (int h = 0; h < N_HALF; h++) begin
         if (!cs_n[h]) begin
            pick_buf  = pick_buf | buf_h[h];
            pick_busy = pick_busy | busy_h[h];
            pick_on   = pick_on | disp_on[h];
         end
      end
   end

   assign db_o  = rs ? pick_buf : status_byte(pick_busy, pick_on, ~rst_n);
   assign db_oe = en & rw & one_sel;

   AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n) |-> !db_oe); // R6
   AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      db_oe |-> (en && rw)); // R7

endmodule

// File: tb/lcd_host_if_tb_top.sv
`timescale 1ns/1ps
module lcd_host_if_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cs_n = 2'b11;
   logic        rs = 1'b0;
   logic        rw = 1'b1;
   logic        en = 1'b0;
   logic [7:0]  db_i = 8'h00;
   logic [7:0]  db_o;
   logic        db_oe;
   logic [1:0]  disp_on;
   logic [11:0] start_line;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   lcd_host_if dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_n       (cs_n),
      .rs         (rs),
      .rw         (rw),
      .en         (en),
      .db_i       (db_i),
      .db_o       (db_o),
      .db_oe      (db_oe),
      .disp_on    (disp_on),
      .start_line (start_line)
   );

   localparam logic [1:0] H0 = 2'b10, H1 = 2'b01, HB = 2'b00, HN = 2'b11;
   localparam logic [1:0] IN = 2'b00, ST = 2'b01, WR = 2'b10, RD = 2'b11;

   // {cs_n, {rs,rw}, data, check, expected}
   localparam int NV = 34;
   localparam logic [20:0] VEC [NV] = '{
      {H0, IN, 8'h3F, 1'b0, 8'h00},  // half 0 on
      {H0, ST, 8'h00, 1'b1, 8'h00},  // R3 on, idle
      {H1, ST, 8'h00, 1'b1, 8'h20},  // R3 half 1 off
      {H0, IN, 8'hBA, 1'b0, 8'h00},  // page 2
      {H0, IN, 8'h4A, 1'b0, 8'h00},  // column 10
      {H0, WR, 8'hA1, 1'b0, 8'h00},
      {H0, WR, 8'hB2, 1'b0, 8'h00},
      {H0, WR, 8'hC3, 1'b0, 8'h00},
      {H0, IN, 8'h4A, 1'b0, 8'h00},
      {H0, RD, 8'h00, 1'b1, 8'h00},  // R5 dummy = reset buffer
      {H0, RD, 8'h00, 1'b1, 8'hA1},
      {H0, RD, 8'h00, 1'b1, 8'hB2},
      {H0, IN, 8'hBD, 1'b0, 8'h00},  // page 5
      {H0, IN, 8'h4A, 1'b0, 8'h00},
      {H0, RD, 8'h00, 1'b1, 8'hC3},  // R5 stale prefetch
      {H1, IN, 8'hB8, 1'b0, 8'h00},  // page 0
      {H1, IN, 8'h7F, 1'b0, 8'h00},  // column 63
      {H1, WR, 8'h5A, 1'b0, 8'h00},
      {H1, WR, 8'h66, 1'b0, 8'h00},  // R4 wrapped to 0
      {H1, IN, 8'h7F, 1'b0, 8'h00},
      {H1, RD, 8'h00, 1'b1, 8'h00},
      {H1, RD, 8'h00, 1'b1, 8'h5A},
      {H1, RD, 8'h00, 1'b1, 8'h66},
      {HB, IN, 8'hB9, 1'b0, 8'h00},  // R6 page 1 on both
      {HB, IN, 8'h40, 1'b0, 8'h00},
      {HB, WR, 8'h77, 1'b0, 8'h00},
      {H0, IN, 8'h40, 1'b0, 8'h00},
      {H0, RD, 8'h00, 1'b0, 8'h00},
      {H0, RD, 8'h00, 1'b1, 8'h77},
      {H1, IN, 8'h40, 1'b0, 8'h00},
      {H1, RD, 8'h00, 1'b0, 8'h00},
      {H1, RD, 8'h00, 1'b1, 8'h77},
      {HB, IN, 8'hC5, 1'b0, 8'h00},  // start line 5 on both
      {H0, IN, 8'h00, 1'b0, 8'h00}   // R2 unknown code
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic bcyc(input logic [1:0] cs, input logic [1:0] cy, input logic [7:0] d,
                       output logic [7:0] got, output logic oe);
      @(negedge clk);
      cs_n = cs; rs = cy[1]; rw = cy[0]; db_i = d; en = 1'b1;
      @(negedge clk);
      got = db_o; oe = db_oe;
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      cs_n = HN;
      repeat (6) @(negedge clk);
   endtask

   // strobe whose fall is detected k clocks after the previous detected fall
   task automatic strobe_after(input int k, input logic [1:0] cs, input logic [1:0] cy,
                               input logic [7:0] d);
      repeat (k - 1) @(negedge clk);
      cs_n = cs; rs = cy[1]; rw = cy[0]; db_i = d; en = 1'b1;
      @(negedge clk);
      en = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      cs_n = HN;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] got;
      logic       oe;

      repeat (4) @(negedge clk);
      chk("R8 reset start", 32'(start_line), 32'h0);
      chk("R8 reset display", 32'(disp_on), 32'h0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7 idle bus", 32'(db_oe), 32'h0);

      // Table walk: R1 R2 R3 R4 R5 R6
      for (int i = 0; i < NV; i++) begin
         bcyc(VEC[i][20:19], VEC[i][18:17], VEC[i][16:9], got, oe);
         if (VEC[i][8]) begin
            chk($sformatf("R1/R3/R4/R5 step %0d data", i), 32'(got), 32'(VEC[i][7:0]));
            chk($sformatf("R7 step %0d enable", i), 32'(oe), 32'h1);
         end
      end

      chk("R2 start lines", 32'(start_line), {20'h0, 6'd5, 6'd5});
      chk("R2 display state", 32'(disp_on), 32'h1);

      // R6: no select, both selects on read
      bcyc(HN, IN, 8'h3F, got, oe);
      chk("R6 unselected instr", 32'(disp_on), 32'h1);
      bcyc(HN, ST, 8'h00, got, oe);
      chk("R6 unselected read drive", 32'(oe), 32'h0);
      bcyc(HB, RD, 8'h00, got, oe);
      chk("R6 dual select read drive", 32'(oe), 32'h0);

      // R9 busy bit right after an access
      strobe_after(1, H0, IN, 8'hC8);
      @(negedge clk);
      rs = 1'b0; rw = 1'b1; en = 1'b1;
      @(negedge clk);
      chk("R9 status busy", 32'(db_o), 32'h80);
      en = 1'b0;
      settle();
      bcyc(H0, ST, 8'h00, got, oe);
      chk("R9 status idle", 32'(got), 32'h00);
      chk("R9 first accepted", 32'(start_line[5:0]), 32'd8);

      // R9 boundary: fall at BUSY_CYCLES rejected, at BUSY_CYCLES+1 accepted
      strobe_after(1, H0, IN, 8'hCA);
      strobe_after(4, H0, IN, 8'hCC);
      settle();
      chk("R9 rejected inside window", 32'(start_line[5:0]), 32'd10);
      strobe_after(1, H0, IN, 8'hCB);
      strobe_after(5, H0, IN, 8'hCD);
      settle();
      chk("R9 accepted after window", 32'(start_line[5:0]), 32'd13);

      // R8 reset behaviour
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8 start forced", 32'(start_line), 32'h0);
      chk("R8 display forced", 32'(disp_on), 32'h0);
      bcyc(H0, ST, 8'h00, got, oe);
      chk("R8 status in reset", 32'(got), 32'hB0);
      chk("R8 status drive", 32'(oe), 32'h1);
      bcyc(H0, IN, 8'h3F, got, oe);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R8 instr ignored", 32'(disp_on), 32'h0);
      bcyc(H0, ST, 8'h00, got, oe);
      chk("R3 status after reset", 32'(got), 32'h20);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule